// File: doc/BRIEF.md
# Display FIFO Threshold Request Generator

This block decides when each of three video output FIFOs (one luma, two chroma) has enough free room to accept another DMA burst, and raises a request line for that FIFO. Free space arrives as a count of 64-bit double words for each FIFO. The block compares each count against a threshold and raises the request when the count reaches it.

Two thresholds are held on chip, one for each interlaced field, so the two fields can have different line lengths. A field indicator selects the active threshold. It is sampled only on a start-of-line strobe, so the threshold never changes in the middle of a line. The luma FIFO compares against the active threshold directly. Both chroma FIFOs compare against half of it, rounded up to a whole double word. In raw mode only the luma path issues requests.

A request stays high until its one-cycle acknowledge arrives. After the acknowledge the request drops for at least one cycle, so one opening in a FIFO yields one burst. A port enable holds every request low. This keeps a zero threshold from requesting without end.

Top module: `dfifo_req_gen`

## Requirements
- R1: After reset both thresholds are 0, the field indicator is field 1 and all three requests are low.
- R2: A cycle with `thr_we` high writes `thr_wdata` into the field-1 threshold when `thr_sel` is 0, or into the field-2 threshold when `thr_sel` is 1. The other threshold keeps its value.
- R3: The luma request is not asserted while the luma free count is below the active threshold T. When the request is low, the port is enabled and the count is at least T, the request rises on the next clock edge.
- R4: Each chroma request follows the R3 rule against its own free count, with a threshold of (T + (T mod 2)) / 2, which is T/2 rounded up.
- R5: The field indicator is captured only on a clock edge where `sol` is high. Value 1 selects the field-2 threshold and value 0 selects the field-1 threshold. A change in `field2` has no effect until that edge.
- R6: Once a request is high, it stays high while the port is enabled and its acknowledge is low, whatever its free count does.
- R7: A high request with its acknowledge high is low after the next clock edge. From the edge after that it is evaluated again under R3 or R4.
- R8: While `raw_mode` is 1, both chroma requests are low from the next clock edge on. The luma path keeps working as in R3.
- R9: While `port_en` is 0, all requests are low from the next clock edge on, even with a threshold of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| port_en | input | 1 | Enables request generation |
| raw_mode | input | 1 | 1 = raw mode, only the luma path is serviced |
| field2 | input | 1 | Field indicator, 1 = field 2 is being output |
| sol | input | 1 | Start-of-line strobe that captures `field2` |
| thr_we | input | 1 | Threshold write strobe |
| thr_sel | input | 1 | Write target: 0 = field 1, 1 = field 2 |
| thr_wdata | input | THR_W | Threshold value, in double words |
| free_y | input | FREE_W | Luma FIFO free space, in double words |
| free_cb | input | FREE_W | Cb FIFO free space, in double words |
| free_cr | input | FREE_W | Cr FIFO free space, in double words |
| ack_y | input | 1 | Luma DMA acknowledge, one cycle |
| ack_cb | input | 1 | Cb DMA acknowledge, one cycle |
| ack_cr | input | 1 | Cr DMA acknowledge, one cycle |
| req_y | output | 1 | Luma DMA request |
| req_cb | output | 1 | Cb DMA request |
| req_cr | output | 1 | Cr DMA request |

## Verification
The bench builds the block with THR_W = 4 and FREE_W = 5. Every threshold from 0 to 15 is then compared against every free count from 0 to 31. This covers each odd and even threshold at the rounded-up chroma boundary, one below it and one above it. It also covers the zero threshold and the case where the free count exceeds any threshold. At this width the field-switch, hold, acknowledge, raw-mode and disable sequences use threshold pairs whose luma and chroma outcomes differ, so each rule shows up at the request pins.

// File: rtl/dfifo_req_pkg.sv
package dfifo_req_pkg;
  localparam int unsigned NUM_CH = 3;
  typedef enum logic [1:0] {
    CH_Y  = 2'd0,
    CH_CB = 2'd1,
    CH_CR = 2'd2
  } ch_e;
endpackage

// File: rtl/dfifo_rst_sync.sv
module dfifo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/dfifo_thr_regs.sv
module dfifo_thr_regs #(
  parameter int unsigned THR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_we,
  input  logic             thr_sel,
  input  logic [THR_W-1:0] thr_wdata,
  input  logic             field2,
  input  logic             sol,
  output logic [THR_W-1:0] thr_luma,
  output logic [THR_W-1:0] thr_chroma
);
  localparam int unsigned SUM_W = THR_W + 1;

  logic [THR_W-1:0] thr1_q, thr1_d;
  logic [THR_W-1:0] thr2_q, thr2_d;
  logic             fld_q, fld_d;
  logic             thr1_en, thr2_en;
  logic [SUM_W-1:0] half_sum;

  // Write enables per field register.
  assign thr1_en = thr_we && !thr_sel;
  assign thr2_en = thr_we &&  thr_sel;

  always_comb begin
    thr1_d = thr1_en ? thr_wdata : thr1_q;
    thr2_d = thr2_en ? thr_wdata : thr2_q;
    fld_d  = sol ? field2 : fld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr1_q <= '0;
      thr2_q <= '0;
      fld_q  <= 1'b0;
    end else begin
      thr1_q <= thr1_d;
      thr2_q <= thr2_d;
      fld_q  <= fld_d;
    end
  end

  // Active threshold and the rounded-up half used by chroma.
  assign thr_luma   = fld_q ? thr2_q : thr1_q;
  assign half_sum   = {1'b0, thr_luma} + {{THR_W{1'b0}}, thr_luma[0]};
  assign thr_chroma = half_sum[SUM_W-1:1];

  p_field_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sol |=> $stable(fld_q));
  p_field_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sol |=> (fld_q == $past(field2)));
  p_keep_other_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_we && thr_sel) |=> $stable(thr1_q));
endmodule

// File: rtl/dfifo_req_chan.sv
module dfifo_req_chan #(
  parameter int unsigned THR_W  = 10,
  parameter int unsigned FREE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [FREE_W-1:0] free_cnt,
  input  logic [THR_W-1:0]  thr,
  input  logic              ack,
  output logic              req
);
  localparam int unsigned CMP_W = (FREE_W > THR_W) ? FREE_W : THR_W;

  logic [CMP_W-1:0] free_ext, thr_ext;
  logic             room;
  logic             req_q, req_d;

  assign free_ext = CMP_W'(free_cnt);
  assign thr_ext  = CMP_W'(thr);
  assign room     = (free_ext >= thr_ext);

  // A held request waits for its acknowledge; an idle one compares.
  always_comb begin
    if (!en)        req_d = 1'b0;
    else if (req_q) req_d = !ack;
    else            req_d = room;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req = req_q;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack && en) |=> req_q);
  p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && ack) |=> !req_q);
  p_no_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && (free_ext < thr_ext)) |=> !req_q);
  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !req_q);
endmodule

// File: rtl/dfifo_req_gen.sv
module dfifo_req_gen #(
  parameter int unsigned THR_W  = 10,
  parameter int unsigned FREE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              raw_mode,
  input  logic              field2,
  input  logic              sol,
  input  logic              thr_we,
  input  logic              thr_sel,
  input  logic [THR_W-1:0]  thr_wdata,
  input  logic [FREE_W-1:0] free_y,
  input  logic [FREE_W-1:0] free_cb,
  input  logic [FREE_W-1:0] free_cr,
  input  logic              ack_y,
  input  logic              ack_cb,
  input  logic              ack_cr,
  output logic              req_y,
  output logic              req_cb,
  output logic              req_cr
);
  import dfifo_req_pkg::*;

  logic                     rst_n_s;
  logic [THR_W-1:0]         thr_luma, thr_chroma;
  logic [NUM_CH-1:0]        ch_en, ch_ack, ch_req;
  logic [NUM_CH-1:0][FREE_W-1:0] ch_free;
  logic [NUM_CH-1:0][THR_W-1:0]  ch_thr;

  dfifo_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  dfifo_thr_regs #(.THR_W(THR_W)) u_thr (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .thr_we     (thr_we),
    .thr_sel    (thr_sel),
    .thr_wdata  (thr_wdata),
    .field2     (field2),
    .sol        (sol),
    .thr_luma   (thr_luma),
    .thr_chroma (thr_chroma)
  );

  always_comb begin
    ch_free[CH_Y]  = free_y;
    ch_free[CH_CB] = free_cb;
    ch_free[CH_CR] = free_cr;
    ch_ack[CH_Y]   = ack_y;
    ch_ack[CH_CB]  = ack_cb;
    ch_ack[CH_CR]  = ack_cr;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    if (g == CH_Y) begin : g_luma
      assign ch_thr[g] = thr_luma;
      assign ch_en[g]  = port_en;
    end else begin : g_chroma
      assign ch_thr[g] = thr_chroma;
      assign ch_en[g]  = port_en && !raw_mode;
    end

    dfifo_req_chan #(.THR_W(THR_W), .FREE_W(FREE_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .en       (ch_en[g]),
      .free_cnt (ch_free[g]),
      .thr      (ch_thr[g]),
      .ack      (ch_ack[g]),
      .req      (ch_req[g])
    );
  end

  assign req_y  = ch_req[CH_Y];
  assign req_cb = ch_req[CH_CB];
  assign req_cr = ch_req[CH_CR];

  p_raw_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    raw_mode |=> (!req_cb && !req_cr));
  p_port_off_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !port_en |=> (ch_req == '0));
  p_chroma_rule_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!req_cb && (32'(free_cb) * 2 < 32'(thr_luma))) |=> !req_cb);
endmodule

// File: tb/dfifo_req_gen_test.sv
module dfifo_req_gen_test;
  localparam int unsigned TW = 4;
  localparam int unsigned FW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 0, raw_mode = 0, field2 = 0, sol = 0;
  logic thr_we = 0, thr_sel = 0;
  logic [TW-1:0] thr_wdata = '0;
  logic [FW-1:0] free_y = '0, free_cb = '0, free_cr = '0;
  logic ack_y = 0, ack_cb = 0, ack_cr = 0;
  logic req_y, req_cb, req_cr;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dfifo_req_gen #(.THR_W(TW), .FREE_W(FW)) uut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .raw_mode(raw_mode),
    .field2(field2), .sol(sol), .thr_we(thr_we), .thr_sel(thr_sel),
    .thr_wdata(thr_wdata), .free_y(free_y), .free_cb(free_cb),
    .free_cr(free_cr), .ack_y(ack_y), .ack_cb(ack_cb), .ack_cr(ack_cr),
    .req_y(req_y), .req_cb(req_cb), .req_cr(req_cr)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic write_thr(input logic sel, input int val);
    @(negedge clk);
    thr_we = 1; thr_sel = sel; thr_wdata = TW'(val);
    @(negedge clk);
    thr_we = 0;
  endtask

  task automatic pulse_sol();
    @(negedge clk); sol = 1;
    @(negedge clk); sol = 0;
  endtask

  // Clear requests, then let one enabled edge evaluate free count f.
  task automatic eval(input int f);
    @(negedge clk); port_en = 0;
    @(negedge clk);
    free_y = FW'(f); free_cb = FW'(f); free_cr = FW'(f); port_en = 1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state, then thresholds of 0 request at free count 0.
    chk("R1 req_y reset", req_y, 1'b0);
    chk("R1 req_cb reset", req_cb, 1'b0);
    chk("R1 req_cr reset", req_cr, 1'b0);
    eval(0);
    chk("R1 req_y thr0", req_y, 1'b1);
    chk("R1 req_cb thr0", req_cb, 1'b1);
    chk("R1 req_cr thr0", req_cr, 1'b1);

    // R3/R4 sweep: every threshold, every free count (boundary, below, above).
    for (int t = 0; t < 16; t++) begin
      write_thr(1'b0, t);
      for (int f = 0; f < 32; f++) begin
        int ch_t;
        ch_t = (t + (t % 2)) / 2;
        eval(f);
        chk("R3 luma compare", req_y, 1'(f >= t));
        chk("R4 cb compare", req_cb, 1'(f >= ch_t));
        chk("R4 cr compare", req_cr, 1'(f >= ch_t));
      end
    end

    // R2/R5: field thresholds, switching only at sol.
    write_thr(1'b0, 3);
    write_thr(1'b1, 12);
    field2 = 1;
    eval(5);
    chk("R5 no switch before sol", req_y, 1'b1);
    pulse_sol();
    eval(5);
    chk("R2 field2 thr luma", req_y, 1'b0);
    chk("R2 field2 thr cb", req_cb, 1'b0);
    eval(6);
    chk("R4 field2 cb boundary", req_cb, 1'b1);
    eval(12);
    chk("R5 field2 luma boundary", req_y, 1'b1);
    field2 = 0;
    eval(5);
    chk("R5 still field2", req_y, 1'b0);
    pulse_sol();
    eval(5);
    chk("R5 back to field1", req_y, 1'b1);
    chk("R2 field1 kept", req_cb, 1'b1);

    // R6: hold regardless of free count.
    eval(10);
    free_y = 0; free_cb = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R6 luma held", req_y, 1'b1);
      chk("R6 cb held", req_cb, 1'b1);
    end

    // R7: acknowledge drops request, then re-evaluation.
    ack_y = 1;
    @(negedge clk); ack_y = 0;
    chk("R7 luma drop", req_y, 1'b0);
    chk("R7 cb untouched", req_cb, 1'b1);
    @(negedge clk);
    chk("R7 luma stays low", req_y, 1'b0);
    free_y = 10;
    @(negedge clk);
    chk("R7 luma re-request", req_y, 1'b1);
    ack_cb = 1;
    @(negedge clk); ack_cb = 0;
    chk("R7 cb drop", req_cb, 1'b0);
    @(negedge clk);
    chk("R7 cb gap", req_cb, 1'b0);
    free_cb = 10;
    @(negedge clk);
    chk("R7 cb re-request", req_cb, 1'b1);

    // R8: raw mode silences chroma, luma still works.
    raw_mode = 1;
    @(negedge clk);
    chk("R8 cb dropped", req_cb, 1'b0);
    chk("R8 cr dropped", req_cr, 1'b0);
    eval(31);
    chk("R8 luma active", req_y, 1'b1);
    chk("R8 cb quiet", req_cb, 1'b0);
    chk("R8 cr quiet", req_cr, 1'b0);
    raw_mode = 0;

    // R9: disable forces all low, even with threshold 0.
    write_thr(1'b0, 0);
    eval(0);
    chk("R9 pre luma", req_y, 1'b1);
    port_en = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R9 luma off", req_y, 1'b0);
      chk("R9 cb off", req_cb, 1'b0);
      chk("R9 cr off", req_cr, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule